// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block turns one memory request into the SDRAM command sequence for a single closed-page access. A request carries a bank, a row, a column and a read/write flag, and it is taken on a valid/ready handshake. The sequencer then opens the row, issues the column command once the programmed RAS-to-CAS gap has passed, waits out the access, precharges the bank and waits out the precharge time before it is ready again. No command leaves the block while the mode register is unprogrammed. In every cycle with no command to issue, the command pins carry NOP.

The timing values are inputs, sampled when a request is accepted: RAS-to-CAS delay, CAS latency, a burst-length code, minimum row-active time and precharge time. A surrounding controller owns refresh, initialization and the data path. It raises `mode_ok_i` once the mode register has been set, and it uses `done_o` to learn that the bank is closed again.

Top module: `sdram_seq`

## Requirements
- R1: During and after reset the command pins carry NOP ({ras_n,cas_n,we_n}=111), `done_o` is low, and the block is idle with `req_ready_o` equal to `mode_ok_i`.
- R2: While `mode_ok_i` is low, `req_ready_o` stays low and no activate is issued, whatever `req_valid_i` does.
- R3: In the cycle after the accepting clock edge the pins carry activate (011), with the row on `addr_o` and the bank on `ba_o`.
- R4: The column command (ras_n=1, cas_n=0) is issued exactly T cycles after the activate, where T is `trcd_i` and a value of 0 counts as 1. The column is on the low `addr_o` bits and `addr_o[10]` is 0.
- R5: The column command is a read (we_n=1, code 101) when `req_write_i` was 0 at acceptance, and a write (we_n=0, code 100) when it was 1.
- R6: Precharge (010, `addr_o[10]`=0, same bank on `ba_o`) is issued max(`tras_i`, T + A) cycles after the activate. A is the burst length B for a write and `cas_lat_i` + B for a read.
- R7: `done_o` pulses for exactly one cycle, max(`trp_i`,1) cycles after the precharge, in the same cycle in which `req_ready_o` returns high.
- R8: `req_ready_o` is low from the accepting edge until the `done_o` cycle. A request held valid during that time is not accepted, and no second activate is issued.
- R9: Every cycle without an activate, column or precharge command carries NOP (111).
- R10: `burst_code_i` values 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8.
- R11: The timing inputs and request fields are sampled at acceptance. Changes to them during an access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ok_i | input | 1 | Mode register has been programmed |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BA_W (2) | Bank |
| req_row_i | input | ROW_W (13) | Row address |
| req_col_i | input | COL_W (9) | Starting column |
| trcd_i | input | T_W (4) | RAS-to-CAS delay in cycles |
| cas_lat_i | input | T_W (4) | CAS latency in cycles |
| burst_code_i | input | 2 | Burst length code |
| tras_i | input | T_W (4) | Minimum activate-to-precharge cycles |
| trp_i | input | T_W (4) | Precharge-to-ready cycles |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W (13) | Address pins |
| ba_o | output | BA_W (2) | Bank pins |
| done_o | output | 1 | Access complete, bank precharged |

## Verification
A wrong state or counter value in this block shows up on the command pins within one cycle. Either a command appears a cycle early or late relative to the activate, a strobe combination appears that should be NOP, or `req_ready_o` rises before the precharge interval has ended. The bench therefore compares the command pins against a per-cycle schedule computed from the request's timing values, starting at the activate and ending at `done_o`. Any stuck or skipped state is caught at the first cycle where it changes the pins. A latching error in a request field is visible on `addr_o` and `ba_o` during the activate or column cycle.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_COL,
    ST_ACC,
    ST_PRE,
    ST_RP
  } state_e;

endpackage

// File: rtl/sdram_seq_timing.sv
module sdram_seq_timing #(
  parameter int T_W   = 4,
  parameter int CNT_W = T_W + 2
) (
  input  logic             write_i,
  input  logic [T_W-1:0]   trcd_i,
  input  logic [T_W-1:0]   cas_lat_i,
  input  logic [1:0]       burst_code_i,
  input  logic [T_W-1:0]   tras_i,
  input  logic [T_W-1:0]   trp_i,
  output logic [CNT_W-1:0] trcd_eff_o,
  output logic [CNT_W-1:0] pre_at_o,
  output logic [CNT_W-1:0] trp_eff_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] burst_len;
  logic [CNT_W-1:0] access_len;
  logic [CNT_W-1:0] col_span;
  logic [CNT_W-1:0] tras_ext;

  always_comb begin
    burst_len  = ONE << burst_code_i;
    trcd_eff_o = (trcd_i == '0) ? ONE : CNT_W'(trcd_i);
    trp_eff_o  = (trp_i == '0) ? ONE : CNT_W'(trp_i);
    access_len = write_i ? burst_len : CNT_W'(cas_lat_i) + burst_len;
    col_span   = trcd_eff_o + access_len;
    tras_ext   = CNT_W'(tras_i);
    pre_at_o   = (tras_ext > col_span) ? tras_ext : col_span;
  end

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
  import sdram_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] trcd_i,
  input  logic [CNT_W-1:0] pre_at_i,
  input  logic [CNT_W-1:0] trp_i,
  output state_e           state_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  state_e           state_q;
  logic [CNT_W-1:0] el_q;
  logic [CNT_W-1:0] trcd_q, pre_q, trp_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      el_q    <= '0;
      trcd_q  <= ONE;
      pre_q   <= ONE;
      trp_q   <= ONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            trcd_q  <= trcd_i;
            pre_q   <= pre_at_i;
            trp_q   <= trp_i;
            el_q    <= '0;
            state_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          el_q    <= el_q + ONE;
          state_q <= (trcd_q == ONE) ? ST_COL : ST_RCD;
        end
        ST_RCD: begin
          el_q <= el_q + ONE;
          if (el_q == trcd_q - ONE) state_q <= ST_COL;
        end
        ST_COL, ST_ACC: begin
          if (el_q == pre_q - ONE) begin
            el_q    <= '0;  // precharge interval counted from zero
            state_q <= ST_PRE;
          end else begin
            el_q    <= el_q + ONE;
            state_q <= ST_ACC;
          end
        end
        ST_PRE: begin
          el_q <= el_q + ONE;
          if (trp_q == ONE) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_RP;
          end
        end
        ST_RP: begin
          el_q <= el_q + ONE;
          if (el_q == trp_q - ONE) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

endmodule

// File: rtl/sdram_seq_cmd_enc.sv
module sdram_seq_cmd_enc
  import sdram_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              write_i,
  input  logic [BA_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  state_e            state_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o
);

  logic              write_q;
  logic [BA_W-1:0]   bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [ADDR_W-1:0] row_addr, col_addr;
  cmd_e              cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else if (accept_i) begin
      write_q <= write_i;
      bank_q  <= bank_i;
      row_q   <= row_i;
      col_q   <= col_i;
    end
  end

  always_comb begin
    row_addr         = '0;
    row_addr[ROW_W-1:0] = row_q;
    col_addr         = '0;
    col_addr[COL_W-1:0] = col_q;
    col_addr[AP_BIT] = 1'b0;  // no auto-precharge
  end

  always_comb begin
    cmd    = CMD_NOP;
    addr_o = '0;
    case (state_i)
      ST_ACT: begin
        cmd    = CMD_ACT;
        addr_o = row_addr;
      end
      ST_COL: begin
        cmd    = write_q ? CMD_WR : CMD_RD;
        addr_o = col_addr;
      end
      ST_PRE:  cmd = CMD_PRE;  // addr bit AP_BIT low: this bank only
      default: cmd = CMD_NOP;
    endcase
  end

  assign {ras_n_o, cas_n_o, we_n_o} = cmd;
  assign ba_o = bank_q;

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int T_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_ok_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BA_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [T_W-1:0]    trcd_i,
  input  logic [T_W-1:0]    cas_lat_i,
  input  logic [1:0]        burst_code_i,
  input  logic [T_W-1:0]    tras_i,
  input  logic [T_W-1:0]    trp_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);

  localparam int CNT_W = T_W + 2;

  state_e           state;
  logic             accept;
  logic [CNT_W-1:0] trcd_eff, pre_at, trp_eff;

  assign req_ready_o = (state == ST_IDLE) && mode_ok_i;
  assign accept      = req_valid_i && req_ready_o;

  sdram_seq_timing #(.T_W(T_W), .CNT_W(CNT_W)) u_timing (
    .write_i      (req_write_i),
    .trcd_i       (trcd_i),
    .cas_lat_i    (cas_lat_i),
    .burst_code_i (burst_code_i),
    .tras_i       (tras_i),
    .trp_i        (trp_i),
    .trcd_eff_o   (trcd_eff),
    .pre_at_o     (pre_at),
    .trp_eff_o    (trp_eff)
  );

  sdram_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .trcd_i   (trcd_eff),
    .pre_at_i (pre_at),
    .trp_i    (trp_eff),
    .state_o  (state),
    .done_o   (done_o)
  );

  sdram_seq_cmd_enc #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .write_i  (req_write_i),
    .bank_i   (req_bank_i),
    .row_i    (req_row_i),
    .col_i    (req_col_i),
    .state_i  (state),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .we_n_o   (we_n_o),
    .addr_o   (addr_o),
    .ba_o     (ba_o)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_ok_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  logic [2:0] cmd;
  logic is_act, is_col, is_pre;
  logic row_open, col_seen;

  assign cmd    = {ras_n_o, cas_n_o, we_n_o};
  assign is_act = (cmd == 3'b011);
  assign is_col = (cmd == 3'b101) || (cmd == 3'b100);
  assign is_pre = (cmd == 3'b010);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open <= 1'b0;
      col_seen <= 1'b0;
    end else begin
      if (is_act) row_open <= 1'b1;
      if (is_col) col_seen <= 1'b1;
      if (is_pre) begin
        row_open <= 1'b0;
        col_seen <= 1'b0;
      end
    end
  end

  AST_ACT_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> $past(req_valid_i && req_ready_o && mode_ok_i)); // R2
  AST_ACT_ROW_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> !row_open); // R8
  AST_COL_IN_OPEN_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> (row_open && !col_seen)); // R4
  AST_PRE_AFTER_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> col_seen); // R6
  AST_PRE_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> !addr_o[AP_BIT]); // R6
  AST_LEGAL_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_col || is_pre || cmd == 3'b111)); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o == mode_ok_i) && !row_open); // R7

endmodule

bind sdram_seq sdram_seq_chk #(.ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_ok_i   (mode_ok_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .addr_o      (addr_o),
  .done_o      (done_o)
);

// File: tb/sdram_seq_bench.sv
module sdram_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_ok = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic        wr = 1'b0;
  logic [1:0]  bank = '0;
  logic [12:0] row = '0;
  logic [8:0]  col = '0;
  logic [3:0]  trcd = 4'd1, cl = 4'd2, tras = 4'd1, trp = 4'd1;
  logic [1:0]  bcode = '0;
  logic        ras_n, cas_n, we_n, done;
  logic [12:0] addr;
  logic [1:0]  ba;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_seq u_sdram_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_ok_i(mode_ok),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr),
    .req_bank_i(bank), .req_row_i(row), .req_col_i(col),
    .trcd_i(trcd), .cas_lat_i(cl), .burst_code_i(bcode),
    .tras_i(tras), .trp_i(trp),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .addr_o(addr), .ba_o(ba), .done_o(done)
  );

  typedef struct packed {
    logic        w;
    logic [1:0]  ba;
    logic [12:0] row;
    logic [8:0]  col;
    logic [3:0]  trcd;
    logic [3:0]  cl;
    logic [1:0]  bc;
    logic [3:0]  tras;
    logic [3:0]  trp;
    logic        hold;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 13'h0123, 9'h045, 4'd2,  4'd2, 2'd2, 4'd5,  4'd2,  1'b0},
    '{1'b1, 2'd2, 13'h1abc, 9'h1ff, 4'd3,  4'd3, 2'd3, 4'd4,  4'd3,  1'b1},
    '{1'b0, 2'd3, 13'h0001, 9'h000, 4'd0,  4'd1, 2'd0, 4'd0,  4'd0,  1'b0},
    '{1'b1, 2'd0, 13'h1fff, 9'h0aa, 4'd1,  4'd2, 2'd0, 4'd7,  4'd1,  1'b1},
    '{1'b0, 2'd2, 13'h0800, 9'h155, 4'd15, 4'd3, 2'd1, 4'd15, 4'd15, 1'b0},
    '{1'b1, 2'd1, 13'h0555, 9'h100, 4'd4,  4'd2, 2'd1, 4'd12, 4'd2,  1'b1}
  };

  function automatic int cmd_now();
    return int'({ras_n, cas_n, we_n});
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t t);
    int tr, bl, acc, pre, rp, rdy;
    tr  = (t.trcd == 0) ? 1 : int'(t.trcd);
    bl  = 1 << t.bc;                                   // R10
    acc = t.w ? bl : int'(t.cl) + bl;
    pre = (int'(t.tras) > tr + acc) ? int'(t.tras) : tr + acc;
    rp  = (t.trp == 0) ? 1 : int'(t.trp);
    rdy = pre + rp;
    @(negedge clk);
    wr = t.w; bank = t.ba; row = t.row; col = t.col;
    trcd = t.trcd; cl = t.cl; bcode = t.bc; tras = t.tras; trp = t.trp;
    valid = 1'b1;
    #1 chk(ready == 1'b1, "R2 ready when mode set", int'(ready), 1);
    @(negedge clk);
    // R11: scramble inputs after acceptance
    trcd = ~t.trcd; cl = ~t.cl; bcode = ~t.bc; tras = ~t.tras; trp = ~t.trp;
    wr = ~t.w; bank = ~t.ba; row = ~t.row; col = ~t.col;
    valid = t.hold;
    for (int k = 0; k <= rdy; k++) begin
      if (k == 0) begin
        chk(cmd_now() == 3, "R3 activate code", cmd_now(), 3);
        chk(addr == t.row, "R3 row on addr", int'(addr), int'(t.row));
        chk(ba == t.ba, "R3 bank", int'(ba), int'(t.ba));
      end else if (k == tr) begin
        chk(cmd_now() == (t.w ? 4 : 5), "R4 R5 column command", cmd_now(), t.w ? 4 : 5);
        chk(addr == 13'(t.col), "R4 column addr", int'(addr), int'(t.col));
        chk(ba == t.ba, "R11 bank held", int'(ba), int'(t.ba));
      end else if (k == pre) begin
        chk(cmd_now() == 2, "R6 precharge timing", cmd_now(), 2);
        chk(addr[10] == 1'b0, "R6 single bank", int'(addr[10]), 0);
      end else begin
        chk(cmd_now() == 7, "R9 nop", cmd_now(), 7);
      end
      if (k < rdy) begin
        chk(ready == 1'b0, "R8 busy", int'(ready), 0);
        chk(done == 1'b0, "R7 no early done", int'(done), 0);
        @(negedge clk);
      end else begin
        chk(ready == 1'b1, "R7 ready after trp", int'(ready), 1);
        chk(done == 1'b1, "R7 done pulse", int'(done), 1);
        valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    chk(cmd_now() == 7, "R8 no second activate", cmd_now(), 7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_now() == 7, "R1 nop in reset", cmd_now(), 7);
    chk(done == 1'b0, "R1 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(ready == 1'b0, "R2 locked ready", int'(ready), 0);
      chk(cmd_now() == 7, "R2 no activate while locked", cmd_now(), 7);
    end
    valid = 1'b0;
    @(negedge clk);
    mode_ok = 1'b1;
    #1 chk(ready == 1'b1, "R1 idle ready follows mode", int'(ready), 1);

    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // reset mid-access
    @(negedge clk);
    wr = 1'b0; trcd = 4'd3; cl = 4'd2; bcode = 2'd2; tras = 4'd9; trp = 4'd3;
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1 chk(cmd_now() == 7, "R1 reset forces nop", cmd_now(), 7);
    chk(ready == 1'b1, "R1 reset returns idle", int'(ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(VECS[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule